// File: doc/BRIEF.md
# AXI4 Burst to Dual-RAM Bridge

This block sits between an AXI4 burst master and two plain synchronous RAM ports. Write bursts from the master land in a receive RAM. Read bursts are served from a transmit RAM. Each RAM port is one 128-bit word wide, with 16 byte enables and a 20-bit byte address. The write and read paths are fully independent. Each path carries one burst at a time, and its address-ready signal stays low until that burst has finished.

On the write side, each data beat goes straight through to the RAM write port in the same cycle, so the bridge stores no write data. The write burst ends on the beat that carries the last flag. On the read side, the bridge fetches words from the transmit RAM, which has one cycle of latency, into a small internal buffer. The master is served from that buffer. Fetching is throttled so that the data already in the buffer plus the word still in flight never exceeds the buffer capacity. Back-pressure on the read data channel therefore never drops a word.

Top module: `axi_burst_ram_bridge`

## Requirements
- R1: During reset and on the first cycle after it, `s_awready` and `s_arready` are 1, and `s_wready`, `s_bvalid`, `s_rvalid`, `rx_we` and `tx_re` are 0.
- R2: In the cycle after a write address is accepted, `s_awready` is 0 and `s_wready` is 1. A write address offered while a write burst is in progress is ignored, and the RAM write addresses keep following the burst already in progress.
- R3: The RAM write address of the first beat equals `s_awaddr`. Each accepted beat advances it by 16, modulo 2^20.
- R4: On every cycle where `s_wvalid` and `s_wready` are both 1, `rx_we` is 1, `rx_wbe` equals `s_wstrb` and `rx_wdata` equals `s_wdata`. On every other cycle `rx_we` is 0. Every beat of a write burst other than the first and the last has all 16 strobes set.
- R5: After the beat with `s_wlast` = 1, `s_bvalid` is 1 and `s_bresp` is 2'b00 (OKAY). `s_awready` is 1 again in the cycle after the B handshake.
- R6: In the cycle after a read address is accepted, `s_arready` is 0. The transmit RAM is read from `s_araddr` upward in steps of 16, modulo 2^20, for exactly `s_arlen`+1 words.
- R7: Read beats return the transmit RAM words in address order, with no word lost or repeated under any pattern of `s_rready`. `s_rvalid` is 0 while no read burst is in progress.
- R8: `s_rlast` is 1 only on the final beat, and `s_rresp` is 2'b00. `s_arready` is 1 again in the cycle after the handshake of the final beat.
- R9: A write burst and a read burst can be in progress at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_awaddr | input | 20 | Write burst start byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 128 | Write data |
| s_wstrb | input | 16 | Write byte strobes |
| s_wlast | input | 1 | Final write beat |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 20 | Read burst start byte address |
| s_arlen | input | 8 | Read burst length minus one |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 128 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rlast | output | 1 | Final read beat |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| rx_we | output | 1 | Receive RAM write enable |
| rx_waddr | output | 20 | Receive RAM write byte address |
| rx_wbe | output | 16 | Receive RAM byte enables |
| rx_wdata | output | 128 | Receive RAM write data |
| tx_re | output | 1 | Transmit RAM read enable |
| tx_raddr | output | 20 | Transmit RAM read byte address |
| tx_rdata | input | 128 | Transmit RAM read data, one cycle after `tx_re` |

## Verification
The bench drives long read bursts while `s_rready` toggles in an irregular pattern. A bridge that fetched without counting the word still in flight would overrun its buffer, and beats would come back out of order or go missing. The bench also offers a second write address in the middle of a write burst. A bridge that accepted it would show a jump in the receive RAM addresses. Bursts that start near the top of the 20-bit space check that the addresses wrap modulo 2^20. Single-beat bursts check that the last flag and the one-cycle return of the ready signals do not fire a beat early or late. A write burst and a read burst run at the same time to show the two paths do not share state.

// File: rtl/axi_bridge_pkg.sv
package axi_bridge_pkg;

   typedef enum logic [1:0] {
      WR_IDLE = 2'd0,
      WR_DATA = 2'd1,
      WR_RESP = 2'd2
   } wr_state_e;

   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_BUSY = 1'b1
   } rd_state_e;

   localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/bridge_prefetch_buf.sv
module bridge_prefetch_buf #(
   parameter int WIDTH = 128,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head_data,
   output logic             not_empty,
   output logic [CNT_W-1:0] fill
);

   localparam bit IS_POW2 = ((1 << PTR_W) == DEPTH);

   logic [WIDTH-1:0] store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count_q;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) store[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count_q <= count_q + CNT_W'(1);
            2'b01:   count_q <= count_q - CNT_W'(1);
            default: count_q <= count_q;
         endcase
      end
   end

   assign head_data = store[rd_ptr];
   assign not_empty = (count_q != '0);
   assign fill      = count_q;

   // R7: the buffer never takes a word it has no room for
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (count_q < CNT_W'(DEPTH)));

   // R7: a pop always finds data in the buffer
   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> not_empty);

endmodule

// File: rtl/bridge_wr_chan.sv
module bridge_wr_chan
   import axi_bridge_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 128,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wlast,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_waddr,
   output logic [STRB_W-1:0] ram_be,
   output logic [DATA_W-1:0] ram_wdata
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRB_W);

   wr_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              first_q;
   logic              beat;

   assign awready = (state_q == WR_IDLE);
   assign wready  = (state_q == WR_DATA);
   assign bvalid  = (state_q == WR_RESP);
   assign bresp   = RESP_OKAY;
   assign beat    = wvalid && wready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WR_IDLE;
         addr_q  <= '0;
         first_q <= 1'b0;
      end else begin
         case (state_q)
            WR_IDLE: if (awvalid) begin
               state_q <= WR_DATA;
               addr_q  <= awaddr;
               first_q <= 1'b1;
            end
            WR_DATA: if (beat) begin
               addr_q  <= addr_q + STEP;
               first_q <= 1'b0;
               if (wlast) state_q <= WR_RESP;
            end
            WR_RESP: if (bready) state_q <= WR_IDLE;
            default: state_q <= WR_IDLE;
         endcase
      end
   end

   assign ram_we    = beat;
   assign ram_waddr = addr_q;
   assign ram_be    = wstrb;
   assign ram_wdata = wdata;

   // R2: an accepted address opens the data phase on the next cycle
   p_wready_after_aw_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid && awready) |=> (wready && !awready));

   // R3: the RAM address steps by one word per accepted beat
   p_waddr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !wlast) |=> (ram_waddr == $past(ram_waddr) + STEP));

   // R4: interior beats carry full strobes
   p_full_interior_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !first_q && !wlast) |-> (&wstrb));

   // R5: address ready returns one cycle after the response handshake
   p_aw_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && bready) |=> awready);

endmodule

// File: rtl/bridge_rd_chan.sv
module bridge_rd_chan
   import axi_bridge_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 128,
   parameter int LEN_W     = 8,
   parameter int BUF_DEPTH = 4,
   localparam int STRB_W   = DATA_W / 8,
   localparam int CNT_W    = LEN_W + 1,
   localparam int FILL_W   = $clog2(BUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] araddr,
   input  logic [LEN_W-1:0]  arlen,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rlast,
   output logic              rvalid,
   input  logic              rready,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_raddr,
   input  logic [DATA_W-1:0] ram_rdata
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRB_W);

   rd_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  fetch_left_q;
   logic [CNT_W-1:0]  beats_left_q;
   logic              inflight_q;
   logic              pop;
   logic              room;
   logic [FILL_W-1:0] fill;
   logic [FILL_W:0]   committed;

   assign arready   = (state_q == RD_IDLE);
   assign committed = {1'b0, fill} + (FILL_W + 1)'(inflight_q);
   assign room      = (committed < (FILL_W + 1)'(BUF_DEPTH));
   assign ram_re    = (state_q == RD_BUSY) && (fetch_left_q != '0) && room;
   assign ram_raddr = addr_q;
   assign pop       = rvalid && rready;
   assign rlast     = (beats_left_q == CNT_W'(1));
   assign rresp     = RESP_OKAY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= RD_IDLE;
         addr_q       <= '0;
         fetch_left_q <= '0;
         beats_left_q <= '0;
         inflight_q   <= 1'b0;
      end else begin
         inflight_q <= ram_re;
         case (state_q)
            RD_IDLE: if (arvalid) begin
               state_q      <= RD_BUSY;
               addr_q       <= araddr;
               fetch_left_q <= {1'b0, arlen} + CNT_W'(1);
               beats_left_q <= {1'b0, arlen} + CNT_W'(1);
            end
            RD_BUSY: begin
               if (ram_re) begin
                  addr_q       <= addr_q + STEP;
                  fetch_left_q <= fetch_left_q - CNT_W'(1);
               end
               if (pop) begin
                  beats_left_q <= beats_left_q - CNT_W'(1);
                  if (rlast) state_q <= RD_IDLE;
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   bridge_prefetch_buf #(
      .WIDTH (DATA_W),
      .DEPTH (BUF_DEPTH)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (inflight_q),
      .push_data (ram_rdata),
      .pop       (pop),
      .head_data (rdata),
      .not_empty (rvalid),
      .fill      (fill)
   );

   // R6: address ready drops after the read address is taken
   p_ar_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (arvalid && arready) |=> !arready);

   // R6: successive RAM reads step by one word
   p_raddr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |=> (ram_raddr == $past(ram_raddr) + STEP));

   // R7: no read data shows while no burst is open
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      arready |-> !rvalid);

   // R8: address ready returns one cycle after the final beat
   p_ar_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && rready && rlast) |=> arready);

endmodule

// File: rtl/axi_burst_ram_bridge.sv
module axi_burst_ram_bridge #(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 128,
   parameter int LEN_W     = 8,
   parameter int BUF_DEPTH = 4,
   localparam int STRB_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   input  logic              s_wlast,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic [LEN_W-1:0]  s_arlen,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rlast,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              rx_we,
   output logic [ADDR_W-1:0] rx_waddr,
   output logic [STRB_W-1:0] rx_wbe,
   output logic [DATA_W-1:0] rx_wdata,
   output logic              tx_re,
   output logic [ADDR_W-1:0] tx_raddr,
   input  logic [DATA_W-1:0] tx_rdata
);

   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if ((1 << $clog2(STRB_W)) != STRB_W) begin : g_bad_strb
         $error("byte lanes per word must be a power of two");
      end
      if (BUF_DEPTH < 2) begin : g_bad_depth
         $error("BUF_DEPTH must be at least 2");
      end
      if (ADDR_W <= $clog2(STRB_W)) begin : g_bad_addr
         $error("ADDR_W too small for the word size");
      end
   endgenerate

   bridge_wr_chan #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .awaddr    (s_awaddr),
      .awvalid   (s_awvalid),
      .awready   (s_awready),
      .wdata     (s_wdata),
      .wstrb     (s_wstrb),
      .wlast     (s_wlast),
      .wvalid    (s_wvalid),
      .wready    (s_wready),
      .bresp     (s_bresp),
      .bvalid    (s_bvalid),
      .bready    (s_bready),
      .ram_we    (rx_we),
      .ram_waddr (rx_waddr),
      .ram_be    (rx_wbe),
      .ram_wdata (rx_wdata)
   );

   bridge_rd_chan #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .LEN_W     (LEN_W),
      .BUF_DEPTH (BUF_DEPTH)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .araddr    (s_araddr),
      .arlen     (s_arlen),
      .arvalid   (s_arvalid),
      .arready   (s_arready),
      .rdata     (s_rdata),
      .rresp     (s_rresp),
      .rlast     (s_rlast),
      .rvalid    (s_rvalid),
      .rready    (s_rready),
      .ram_re    (tx_re),
      .ram_raddr (tx_raddr),
      .ram_rdata (tx_rdata)
   );

   // R9: the two paths advance on their own; a read burst does not hold off writes
   p_independent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awvalid && s_awready && !s_arready) |=> s_wready);

endmodule

// File: tb/axi_burst_ram_bridge_test.sv
module axi_burst_ram_bridge_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 20;
   localparam int DW = 128;
   localparam int SW = 16;
   localparam int LW = 8;

   logic          clk, rst_n;
   logic [AW-1:0] awaddr, araddr, rx_waddr, tx_raddr;
   logic          awvalid, awready, wlast, wvalid, wready, bvalid, bready;
   logic [DW-1:0] wdata, rdata, rx_wdata, tx_rdata;
   logic [SW-1:0] wstrb, rx_wbe;
   logic [1:0]    bresp, rresp;
   logic [LW-1:0] arlen;
   logic          arvalid, arready, rlast, rvalid, rready, rx_we, tx_re;

   axi_burst_ram_bridge uut (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wlast(wlast), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_araddr(araddr), .s_arlen(arlen), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rlast(rlast), .s_rvalid(rvalid), .s_rready(rready),
      .rx_we(rx_we), .rx_waddr(rx_waddr), .rx_wbe(rx_wbe), .rx_wdata(rx_wdata),
      .tx_re(tx_re), .tx_raddr(tx_raddr), .tx_rdata(tx_rdata)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      logic [DW-1:0] v;
      for (int j = 0; j < 4; j++) v[j*32 +: 32] = {4'hA, a, 8'(j)};
      return v;
   endfunction

   // transmit RAM: one cycle read latency
   always @(posedge clk) if (tx_re) tx_rdata <= pat(tx_raddr);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // reference model state
   int            wph, rph, m_rlen, m_rk, m_fetch;
   logic [AW-1:0] m_waddr, m_rbase;
   int            total_req, total_got;
   bit            seen_both;
   bit            c_aw, c_w, c_wlast, c_b, c_ar, c_r, c_re;
   logic [AW-1:0] c_awaddr, c_araddr;
   logic [LW-1:0] c_arlen;
   bit            post_reset;

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(awready && arready, "R1", "addr ready in reset", {awready, arready}, 2'b11);
         chk(!(wready || bvalid || rvalid || rx_we || tx_re), "R1", "quiet in reset",
             {wready, bvalid, rvalid, rx_we, tx_re}, 0);
         {c_aw, c_w, c_wlast, c_b, c_ar, c_r, c_re} = '0;
         post_reset = 1'b1;
      end else begin
         if (post_reset) begin
            chk(awready && arready && !wready && !rvalid, "R1", "state after reset",
                {awready, arready, wready, rvalid}, 4'b1100);
            post_reset = 1'b0;
         end
         chk(awready == (wph == 0), "R5", "s_awready", awready, wph == 0);
         chk(wready == (wph == 1), "R2", "s_wready", wready, wph == 1);
         chk(bvalid == (wph == 2), "R5", "s_bvalid", bvalid, wph == 2);
         if (bvalid) chk(bresp == 2'b00, "R5", "s_bresp", bresp, 0);
         if (wph == 1 && wvalid) begin
            chk(rx_we, "R4", "rx_we on beat", rx_we, 1);
            chk(rx_waddr == m_waddr, "R3", "rx_waddr", rx_waddr, m_waddr);
            chk(rx_wbe == wstrb, "R4", "rx_wbe", rx_wbe, wstrb);
            chk(rx_wdata == wdata, "R4", "rx_wdata", rx_wdata, wdata);
         end else begin
            chk(!rx_we, "R4", "rx_we idle", rx_we, 0);
         end
         chk(arready == (rph == 0), "R8", "s_arready", arready, rph == 0);
         if (tx_re) begin
            chk(rph == 1 && m_fetch < m_rlen, "R6", "read count", m_fetch, m_rlen);
            chk(tx_raddr == AW'(m_rbase + AW'(16 * m_fetch)), "R6", "tx_raddr", tx_raddr,
                AW'(m_rbase + AW'(16 * m_fetch)));
         end
         if (rph == 0) chk(!rvalid, "R7", "rvalid while idle", rvalid, 0);
         if (rvalid && rready) begin
            chk(rdata == pat(AW'(m_rbase + AW'(16 * m_rk))), "R7", "s_rdata", rdata,
                pat(AW'(m_rbase + AW'(16 * m_rk))));
            chk(rlast == (m_rk == m_rlen - 1), "R8", "s_rlast", rlast, m_rk == m_rlen - 1);
            chk(rresp == 2'b00, "R8", "s_rresp", rresp, 0);
         end
         if (wph != 0 && rph != 0) seen_both = 1'b1;
         c_aw = awvalid && (wph == 0);  c_awaddr = awaddr;
         c_w  = wvalid && (wph == 1);   c_wlast  = wlast;
         c_b  = bready && (wph == 2);
         c_ar = arvalid && (rph == 0);  c_araddr = araddr;  c_arlen = arlen;
         c_r  = rvalid && rready;       c_re     = tx_re;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         wph = 0; rph = 0; m_waddr = '0; m_rbase = '0;
         m_rlen = 0; m_rk = 0; m_fetch = 0;
      end else begin
         case (wph)
            0: if (c_aw) begin wph = 1; m_waddr = c_awaddr; end
            1: if (c_w) begin m_waddr = m_waddr + AW'(16); if (c_wlast) wph = 2; end
            default: if (c_b) wph = 0;
         endcase
         if (rph == 0) begin
            if (c_ar) begin
               rph = 1; m_rbase = c_araddr; m_rlen = int'(c_arlen) + 1; m_rk = 0; m_fetch = 0;
            end
         end else begin
            if (c_re) m_fetch++;
            if (c_r) begin m_rk++; if (m_rk == m_rlen) rph = 0; end
         end
      end
   end

   task automatic do_write(input logic [AW-1:0] a, input int n, input logic [SW-1:0] fs,
                           input logic [SW-1:0] ls, input int gap, input int bdelay,
                           input bit poke);
      bit hs;
      awaddr = a; awvalid = 1'b1;
      forever begin @(negedge clk); hs = awready; @(posedge clk); #1; if (hs) break; end
      awvalid = 1'b0;
      if (poke) begin awvalid = 1'b1; awaddr = a ^ 20'h55550; end
      for (int i = 0; i < n; i++) begin
         if (gap > 0 && i % 2 == 1) begin
            wvalid = 1'b0;
            repeat (gap) @(posedge clk);
            #1;
         end
         wvalid = 1'b1;
         wdata  = {$urandom, $urandom, $urandom, $urandom};
         wstrb  = (n == 1) ? (fs & ls) : (i == 0) ? fs : (i == n - 1) ? ls : '1;
         wlast  = (i == n - 1);
         forever begin @(negedge clk); hs = wready; @(posedge clk); #1; if (hs) break; end
      end
      wvalid = 1'b0; wlast = 1'b0; awvalid = 1'b0;
      repeat (bdelay) @(posedge clk);
      #1;
      bready = 1'b1;
      forever begin @(negedge clk); hs = bvalid; @(posedge clk); #1; if (hs) break; end
      bready = 1'b0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, input int len, input bit throttle,
                          input int seed);
      bit hs, last;
      int st = seed;
      araddr = a; arlen = LW'(len); arvalid = 1'b1;
      forever begin @(negedge clk); hs = arready; @(posedge clk); #1; if (hs) break; end
      arvalid = 1'b0;
      total_req += len + 1;
      forever begin
         st = st * 1103515245 + 12345;
         rready = throttle ? st[16] : 1'b1;
         @(negedge clk); hs = rvalid && rready; last = rlast;
         @(posedge clk); #1;
         if (hs) begin total_got++; if (last) break; end
      end
      rready = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0;
      awaddr = '0; awvalid = 0; wdata = '0; wstrb = '0; wlast = 0; wvalid = 0; bready = 0;
      araddr = '0; arlen = '0; arvalid = 0; rready = 0;
      total_req = 0; total_got = 0; seen_both = 0; post_reset = 0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      // R3 R4: unaligned start, partial first and last beats
      do_write(20'h0001F, 3, 16'h8000, 16'h0003, 0, 0, 0);
      // R5: single beat, response held back
      do_write(20'h00400, 1, 16'hFFF0, 16'h0FFF, 0, 3, 0);
      // R2: second address offered mid-burst, gaps between beats
      do_write(20'h01000, 5, 16'hFFFF, 16'h00FF, 2, 1, 1);
      // R3: address wraps at 2^20
      do_write(20'hFFFF0, 2, 16'hFFFF, 16'hFFFF, 0, 0, 0);
      // R6 R8: single-beat read
      do_read(20'h00100, 0, 0, 1);
      // R7: full-rate long read
      do_read(20'h02000, 7, 0, 2);
      // R7: back-pressured long read
      do_read(20'h03000, 15, 1, 3);
      // R6: read wraps at 2^20
      do_read(20'hFFFE0, 3, 1, 4);
      // R9: both directions at once
      fork
         do_write(20'h04000, 4, 16'hFFFF, 16'hFFFF, 1, 2, 0);
         do_read(20'h05000, 5, 1, 5);
      join
      chk(seen_both, "R9", "write and read open together", seen_both, 1);
      do_read(20'h06000, 40, 1, 6);
      repeat (4) @(posedge clk);
      #1;
      chk(total_got == total_req, "R7", "read beats delivered", total_got, total_req);
      chk(awready && arready, "R8", "both paths idle at end", {awready, arready}, 2'b11);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule